// File: doc/BRIEF.md
# Pulse-Interval Decoder with Self-Calibrated Link Clock

This block sits behind the envelope detector of a passive tag. It runs on the tag's own free-running oscillator, whose frequency drifts with process, supply and temperature. It does not rely on a fixed idea of time. Instead it measures the reader's calibration intervals in oscillator cycles and derives every later decision from those counts.

A frame starts with a falling edge of the envelope while the block is idle. The next interval is the read calibration length. Half of it becomes the 0/1 decision point for the data symbols that follow. If the interval right after the read calibration is longer than it, that interval is the reply calibration length. From it the block computes a return-link period in oscillator cycles, using one of two divide ratios, and produces the link clock by dividing the oscillator.

Each decoded data bit is presented with a one-cycle strobe. When the envelope stays quiet for too long, the block drops the frame and waits for the next one.

Top module: `pie_link_decoder`

## Requirements
- R1: After reset, `bit_valid_o`, `bit_o` and `link_clk_o` are all 0.
- R2: In idle, a falling edge of `env_i` starts a frame. The interval up to the next falling edge is stored as the read calibration count, and the decision point is that count shifted right by one.
- R3: A data interval shorter than the decision point decodes as 0. An interval equal to or longer than it decodes as 1. Bits come out in arrival order.
- R4: Only the interval that directly follows the read calibration can be the reply calibration, and it is taken as such only when it is strictly longer than the read calibration count. In that case no bit is produced for it. Otherwise that interval is decoded as data.
- R5: With `dr_sel_i`=0 (divide ratio 8), the link period is the reply count shifted right by 3. With `dr_sel_i`=1 (divide ratio 64/3), it is (count×3+32)>>6. The result is never below 2, and `dr_sel_i` is sampled only when the reply count is captured.
- R6: `link_clk_o` is low from reset until the first reply calibration is captured. After that it repeats every P cycles and stays high for the first floor(P/2) cycles of each period. A later capture reloads it.
- R7: The interval counter is 12 bits wide and stops at 4095 rather than wrapping. Reaching 4095 while waiting for the read calibration edge returns the block to idle.
- R8: After the read calibration has been captured, an interval that grows past 4× the read calibration count abandons the frame. The next falling edge then starts a fresh frame.
- R9: `env_i` passes through two synchronizing flops. Intervals are counted in whole clock cycles between successive detected falling edges, so a spacing of N cycles at the pin measures as N.
- R10: `bit_valid_o` is high for exactly one cycle per decoded bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tag oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| env_i | input | 1 | Digitized envelope, asynchronous to clk |
| dr_sel_i | input | 1 | Divide ratio select: 0 for 8, 1 for 64/3 |
| bit_o | output | 1 | Decoded data bit |
| bit_valid_o | output | 1 | One-cycle strobe marking bit_o |
| link_clk_o | output | 1 | Return-link clock divided from clk |

## Verification
The hardest situation to reach from the pins is counter saturation while the block waits for the read calibration edge. It needs a lone falling edge followed by more than 4095 quiet cycles. The bench drives exactly that and then sends a normal frame whose decoded bits only come out right if the block went back to idle. Decision-point boundaries (pivot−1 and pivot), an after-calibration interval equal to the read calibration count, and a reply count small enough to hit the minimum period are all driven with exact cycle spacing, because the synchronizer delay cancels between edges.

// File: rtl/pie_pkg.sv
package pie_pkg;

    localparam int CNT_W_DEF       = 12;
    localparam int SYNC_STAGES_DEF = 2;
    localparam int MIN_LINK_PERIOD = 2;
    localparam int ABORT_SHIFT     = 2;   // abort window = rt << ABORT_SHIFT

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RTCAL = 2'd1,
        ST_FIRST = 2'd2,
        ST_DATA  = 2'd3
    } pie_state_e;

    typedef struct packed {
        logic valid;
        logic value;
    } pie_bit_t;

    // Link period in oscillator cycles from a reply-calibration count.
    function automatic int unsigned link_period_cycles(input int unsigned tr,
                                                       input logic dr_third);
        int unsigned p;
        if (dr_third) p = (tr * 3 + 32) >> 6;
        else          p = tr >> 3;
        if (p < MIN_LINK_PERIOD) p = MIN_LINK_PERIOD;
        return p;
    endfunction

endpackage

// File: rtl/pie_edge_sync.sv
module pie_edge_sync #(
    parameter int STAGES = pie_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b1;
                else     sync_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/pie_interval_cnt.sv
module pie_interval_cnt #(
    parameter int W = pie_pkg::CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] cnt_o,
    output logic         sat_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (restart)          cnt_q <= W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;
    assign sat_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pie_frame_ctrl.sv
module pie_frame_ctrl
    import pie_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fall,
    input  logic [W-1:0] cnt,
    input  logic         sat,
    input  logic         dr_sel,
    output pie_bit_t     bit_o,
    output logic         tr_load_o,
    output logic [W-1:0] period_o,
    output pie_state_e   state_o,
    output logic [W-1:0] rt_o
);
    localparam int WIDE = W + ABORT_SHIFT;

    pie_state_e   state_q;
    logic [W-1:0] rt_q;
    logic [W-1:0] pivot;
    logic [W-1:0] period_q;
    pie_bit_t     bit_q;
    logic         tr_load_q;
    logic         over;
    logic         is_one;

    assign pivot  = rt_q >> 1;
    assign is_one = (cnt >= pivot);
    assign over   = ({{ABORT_SHIFT{1'b0}}, cnt} > ({rt_q, {ABORT_SHIFT{1'b0}}}))
                    || sat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rt_q      <= '0;
            period_q  <= W'(MIN_LINK_PERIOD);
            bit_q     <= '0;
            tr_load_q <= 1'b0;
        end else begin
            bit_q.valid <= 1'b0;
            tr_load_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fall) state_q <= ST_RTCAL;
                end
                ST_RTCAL: begin
                    if (fall) begin
                        rt_q    <= cnt;
                        state_q <= ST_FIRST;
                    end else if (sat) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_FIRST: begin
                    if (fall) begin
                        if (cnt > rt_q) begin
                            tr_load_q <= 1'b1;
                            period_q  <= W'(link_period_cycles(32'(cnt), dr_sel));
                        end else begin
                            bit_q.valid <= 1'b1;
                            bit_q.value <= is_one;
                        end
                        state_q <= ST_DATA;
                    end else if (over) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        bit_q.valid <= 1'b1;
                        bit_q.value <= is_one;
                    end else if (over) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bit_o     = bit_q;
    assign tr_load_o = tr_load_q;
    assign period_o  = period_q;
    assign state_o   = state_q;
    assign rt_o      = rt_q;

    logic unused_wide;
    assign unused_wide = (WIDE == 0);
endmodule

// File: rtl/pie_link_clkgen.sv
module pie_link_clkgen #(
    parameter int W = pie_pkg::CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] period_i,
    output logic         run_o,
    output logic         link_clk_o
);
    logic [W-1:0] per_q;
    logic [W-1:0] phase_q;
    logic         run_q;
    logic         clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q   <= '0;
            phase_q <= '0;
            run_q   <= 1'b0;
            clk_q   <= 1'b0;
        end else begin
            if (load) begin
                per_q   <= period_i;
                phase_q <= '0;
                run_q   <= 1'b1;
            end else if (run_q) begin
                phase_q <= (phase_q == per_q - W'(1)) ? '0 : phase_q + W'(1);
            end
            clk_q <= run_q && !load && (phase_q < (per_q >> 1));
        end
    end

    assign run_o      = run_q;
    assign link_clk_o = clk_q;
endmodule

// File: rtl/pie_link_decoder.sv
module pie_link_decoder
    import pie_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic env_i,
    input  logic dr_sel_i,
    output logic bit_o,
    output logic bit_valid_o,
    output logic link_clk_o
);
    logic             fall;
    logic [CNT_W-1:0] cnt;
    logic             sat;
    pie_bit_t         dec_bit;
    logic             tr_load;
    logic [CNT_W-1:0] period;
    pie_state_e       state;
    logic [CNT_W-1:0] rt;
    logic             link_run;

    pie_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (env_i),
        .fall_o (fall)
    );

    pie_interval_cnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (fall),
        .cnt_o   (cnt),
        .sat_o   (sat)
    );

    pie_frame_ctrl #(.W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fall      (fall),
        .cnt       (cnt),
        .sat       (sat),
        .dr_sel    (dr_sel_i),
        .bit_o     (dec_bit),
        .tr_load_o (tr_load),
        .period_o  (period),
        .state_o   (state),
        .rt_o      (rt)
    );

    pie_link_clkgen #(.W(CNT_W)) u_link (
        .clk        (clk),
        .rst        (rst),
        .load       (tr_load),
        .period_i   (period),
        .run_o      (link_run),
        .link_clk_o (link_clk_o)
    );

    assign bit_o       = dec_bit.value;
    assign bit_valid_o = dec_bit.valid;
endmodule

// File: rtl/pie_link_checker.sv
module pie_link_checker
    import pie_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input logic         clk,
    input logic         rst,
    input logic         fall,
    input logic [W-1:0] cnt,
    input logic         sat,
    input pie_state_e   state,
    input logic [W-1:0] rt,
    input logic         bit_valid,
    input logic         tr_load,
    input logic         link_run,
    input logic         link_clk,
    input logic [W-1:0] period
);
    // R10: strobe lasts one cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    // R6: link clock quiet before the first capture
    a_r6_quiet_link: assert property (@(posedge clk) disable iff (rst)
        !link_run |-> !link_clk);

    // R7: counter holds at its ceiling
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (sat && !fall) |=> sat);

    // R8: overlong interval returns to idle
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FIRST || state == ST_DATA) && !fall &&
         ({2'b00, cnt} > {rt, 2'b00})) |=> (state == ST_IDLE));

    // R4: a reply-calibration capture yields no bit
    a_r4_capture_no_bit: assert property (@(posedge clk) disable iff (rst)
        tr_load |-> !bit_valid);

    // R2: edge in idle opens a frame
    a_r2_frame_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fall) |=> (state == ST_RTCAL));

    // R5: period never below the floor
    a_r5_min_period: assert property (@(posedge clk) disable iff (rst)
        tr_load |=> (period >= W'(MIN_LINK_PERIOD)));
endmodule

bind pie_link_decoder pie_link_checker #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .cnt       (cnt),
    .sat       (sat),
    .state     (state),
    .rt        (rt),
    .bit_valid (bit_valid_o),
    .tr_load   (tr_load),
    .link_run  (link_run),
    .link_clk  (link_clk_o),
    .period    (period)
);

// File: tb/sim_pie_link_decoder.sv
`timescale 1ns/1ps
module sim_pie_link_decoder;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic env = 1'b1;
    logic dr_sel = 1'b0;
    logic bit_o, bit_valid_o, link_clk_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pie_link_decoder u0 (
        .clk(clk), .rst(rst), .env_i(env), .dr_sel_i(dr_sel),
        .bit_o(bit_o), .bit_valid_o(bit_valid_o), .link_clk_o(link_clk_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sym(input int n);
        env = 1'b0; cyc(PW);
        env = 1'b1; cyc(n - PW);
    endtask

    task automatic data(input int n, input int pivot, input string tag);
        exp_q.push_back(n >= pivot);
        tag_q.push_back(tag);
        sym(n);
    endtask

    task automatic close_frame(input int rt);
        env = 1'b0; cyc(PW);
        env = 1'b1; cyc(4 * rt + 40);
    endtask

    task automatic measure_link(input int p, input string tag);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        while (link_clk_o !== 1'b0 && guard < 5000) begin cyc(1); guard++; end
        while (link_clk_o !== 1'b1 && guard < 5000) begin cyc(1); guard++; end
        while (link_clk_o === 1'b1 && guard < 5000) begin cyc(1); hi++; guard++; end
        while (link_clk_o === 1'b0 && guard < 5000) begin cyc(1); lo++; guard++; end
        check(hi == p / 2, {tag, " high time"}, hi, p / 2);
        check(hi + lo == p, {tag, " period"}, hi + lo, p);
    endtask

    always @(negedge clk) begin
        if (!rst && bit_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 R3 unexpected bit", int'(bit_o), -1);
            end else begin
                logic e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bit_o === e, t, int'(bit_o), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(1);
        check(bit_valid_o === 1'b0, "R1 valid after reset", int'(bit_valid_o), 0);
        check(bit_o === 1'b0, "R1 bit after reset", int'(bit_o), 0);
        check(link_clk_o === 1'b0, "R1 link clock after reset", int'(link_clk_o), 0);

        // Frame 1: divide by 8, rt=80 pivot=40, tr=200 -> period 25
        dr_sel = 1'b0;
        sym(80);
        check(link_clk_o === 1'b0, "R6 link low before capture", int'(link_clk_o), 0);
        sym(200);
        data(39, 40, "R3 R9 just below pivot");
        data(40, 40, "R3 R9 at pivot");
        data(79, 40, "R3 long one");
        data(80, 40, "R4 data after capture");
        data(30, 40, "R3 short zero");
        data(120, 40, "R3 longer one");
        close_frame(80);
        measure_link(25, "R5 R6 divide by 8");

        // Frame 2: 64/3, rt=60 pivot=30, tr=150 -> (450+32)>>6 = 7
        dr_sel = 1'b1;
        sym(60);
        sym(150);
        data(29, 30, "R3 below pivot frame2");
        data(30, 30, "R3 pivot frame2");
        data(45, 30, "R3 one frame2");
        close_frame(60);
        measure_link(7, "R5 R6 divide by 64/3");

        // Frame 3: interval equal to rt is data, no recapture; select ignored
        dr_sel = 1'b0;
        sym(100);
        data(100, 50, "R4 equal to rt decodes as data");
        data(49, 50, "R3 zero frame3");
        data(50, 50, "R3 one frame3");
        close_frame(100);
        measure_link(7, "R5 R4 period kept without capture");

        // Saturation while awaiting rt edge, then a normal frame
        env = 1'b0; cyc(PW);
        env = 1'b1; cyc(4300);
        sym(64);
        sym(250);
        data(31, 32, "R7 zero after saturation");
        data(32, 32, "R7 one after saturation");
        close_frame(64);
        measure_link(31, "R7 R6 reload period 31");

        // Minimum period clamp: 64/3, tr=30 -> 1 -> 2
        dr_sel = 1'b1;
        sym(20);
        sym(30);
        data(9, 10, "R3 R8 zero after abort");
        data(10, 10, "R3 R8 one after abort");
        close_frame(20);
        measure_link(2, "R5 minimum period");

        cyc(10);
        check(exp_q.size() == 0, "R3 R10 all bits delivered once", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule